// File: doc/BRIEF.md
# Multi-Queue Status Flag Bus Reporter

This block publishes the active-low status flags of a four-queue device on a narrow status bus that several cascaded devices share. Each device holds a fixed device number. A strap sampled while master reset is held chooses one of two reporting modes, and that choice stays fixed until the next master reset.

In direct mode, a strobe carries a device address. The addressed device captures its four queue flags onto the bus and enables its driver. Every other device releases the bus. With no strobe, the bus keeps the last snapshot.

In polled mode, a slot counter shared by all devices steps on each rising clock edge, so each device in turn captures its flags and drives the bus for one cycle. Strobe and address are ignored in this mode.

Separately, a discrete flag output repeats, one clock later, the flag of the queue that is currently selected. The enable output is meant to control a tri-state driver, so that exactly one device owns the shared wires at a time.

Top module: `flag_bus_reporter`

## Requirements
- R1: While the active-low reset is held, busEn is 0 and flagN is 1, whatever the queue flags are.
- R2: pollStrap is sampled only while reset is held (1 = polled, 0 = direct). Changing it after reset has no effect on the mode.
- R3: In direct mode, a clock edge with strobe high and devAddr equal to the device number sets busEn to 1. The same edge loads flagBus with queueFlagN as sampled at that edge, with bit i reporting queue i (0 = flag active).
- R4: In direct mode, a clock edge with strobe high and devAddr naming another device clears busEn.
- R5: In direct mode, an edge with strobe low leaves busEn and flagBus unchanged, even if queueFlagN changes.
- R6: In polled mode, the n-th edge after reset release (n from 1) enables the device whose number is (n-1) mod NUM_DEV. That device's flagBus takes queueFlagN sampled at that edge, and every other device releases the bus.
- R7: In polled mode, strobe and devAddr have no effect on which device drives the bus.
- R8: The poll slot counter starts at device 0 after reset and returns to device 0 after the last device.
- R9: Each edge loads flagN with queueFlagN[selQueue] as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Master reset, active low, synchronous |
| pollStrap | input | 1 | Mode strap sampled during reset (1 = polled) |
| strobe | input | 1 | Direct-mode selection strobe |
| devAddr | input | DEV_BITS | Device addressed by the strobe |
| queueFlagN | input | NUM_QUEUES | Per-queue status flags, active low |
| selQueue | input | SEL_BITS | Queue shown on the discrete flag |
| flagBus | output | NUM_QUEUES | Status bus value, valid while busEn is 1 |
| busEn | output | 1 | Bus driver enable; 0 releases the bus |
| flagN | output | 1 | Discrete flag of the selected queue, active low |

## Verification
Four devices, numbered 0 to 3, share the inputs, and each device gets its own flag pattern. Because the patterns differ, a bus snapshot taken from the wrong device, or taken on the wrong edge, shows up as a mismatch.

The direct-mode sweep covers every address against sixteen flag patterns. Each strobe edge is followed by an idle edge during which the flags change, which separates a held snapshot from a live feed.

The polled run covers several full rounds with strobes and addresses aimed at other devices. This exposes a slot counter that starts wrong, fails to wrap, or listens to the strobe.

The strap is flipped right after each reset release. The discrete flag is checked against a rotating queue selection.

// File: rtl/flag_bus_pkg.sv
package flag_bus_pkg;
  // Strobes from the control toward the bus datapath.
  typedef struct packed {
    logic capture;  // load flags and drive the bus
    logic drop;     // release the bus
  } busCtl_t;
endpackage

// File: rtl/flag_bus_ctrl.sv
module flag_bus_ctrl
  import flag_bus_pkg::*;
#(
  parameter int DEV_BITS = 2,
  parameter int DEV_ID   = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pollStrap,
  input  logic                strobe,
  input  logic [DEV_BITS-1:0] devAddr,
  output busCtl_t             ctl
);
  localparam int NUM_DEV = 1 << DEV_BITS;
  localparam logic [DEV_BITS-1:0] MY_ID    = DEV_BITS'(DEV_ID);
  localparam logic [DEV_BITS-1:0] LAST_DEV = DEV_BITS'(NUM_DEV - 1);

  logic                modePoll;
  logic [DEV_BITS-1:0] pollCnt;
  logic                pollHit;
  logic                addrHit;

  // Mode strap is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePoll <= pollStrap;
      pollCnt  <= '0;
    end else if (modePoll) begin
      pollCnt  <= (pollCnt == LAST_DEV) ? '0 : pollCnt + 1'b1;
    end
  end

  assign pollHit = (pollCnt == MY_ID);
  assign addrHit = strobe && (devAddr == MY_ID);

  always_comb begin
    if (modePoll) begin
      ctl.capture = pollHit;
      ctl.drop    = !pollHit;
    end else begin
      ctl.capture = addrHit;
      ctl.drop    = strobe && !addrHit;
    end
  end

  // R2
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modePoll));

  // R8
  poll_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modePoll && pollCnt == LAST_DEV) |=> (pollCnt == '0));

  // R7
  poll_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modePoll && strobe && devAddr != pollCnt && devAddr == MY_ID) |-> !ctl.capture);
endmodule

// File: rtl/flag_bus_dp.sv
module flag_bus_dp
  import flag_bus_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int SEL_BITS   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busCtl_t               ctl,
  input  logic [NUM_QUEUES-1:0] queueFlagN,
  input  logic [SEL_BITS-1:0]   selQueue,
  output logic [NUM_QUEUES-1:0] flagBus,
  output logic                  busEn,
  output logic                  flagN
);
  // One capture register per queue bit on the bus.
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)            flagBus[q] <= 1'b1;
      else if (ctl.capture) flagBus[q] <= queueFlagN[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busEn <= 1'b0;
      flagN <= 1'b1;
    end else begin
      if (ctl.capture)   busEn <= 1'b1;
      else if (ctl.drop) busEn <= 1'b0;
      flagN <= queueFlagN[selQueue];
    end
  end

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (busEn && flagBus == $past(queueFlagN)));

  // R4
  drop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drop |=> !busEn);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capture && !ctl.drop) |=> ($stable(busEn) && $stable(flagBus)));
endmodule

// File: rtl/flag_bus_reporter.sv
module flag_bus_reporter
  import flag_bus_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int DEV_BITS   = 2,
  parameter int DEV_ID     = 0,
  localparam int SEL_BITS  = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pollStrap,
  input  logic                  strobe,
  input  logic [DEV_BITS-1:0]   devAddr,
  input  logic [NUM_QUEUES-1:0] queueFlagN,
  input  logic [SEL_BITS-1:0]   selQueue,
  output logic [NUM_QUEUES-1:0] flagBus,
  output logic                  busEn,
  output logic                  flagN
);
  busCtl_t ctl;

  flag_bus_ctrl #(.DEV_BITS(DEV_BITS), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .pollStrap(pollStrap),
    .strobe(strobe), .devAddr(devAddr), .ctl(ctl)
  );

  flag_bus_dp #(.NUM_QUEUES(NUM_QUEUES), .SEL_BITS(SEL_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .queueFlagN(queueFlagN),
    .selQueue(selQueue), .flagBus(flagBus), .busEn(busEn), .flagN(flagN)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!busEn && flagN));
endmodule

// File: tb/flag_bus_reporter_test.sv
`timescale 1ns/1ps
module flag_bus_reporter_test;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pollStrap = 1'b0;
  logic strobe = 1'b0;
  logic [1:0] devAddr = '0;
  logic [1:0] selQueue = '0;
  logic [3:0] qf [ND];
  logic [3:0] busOut [ND];
  logic [ND-1:0] en;
  logic [ND-1:0] fN;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  for (genvar d = 0; d < ND; d++) begin : dev
    flag_bus_reporter #(.NUM_QUEUES(4), .DEV_BITS(2), .DEV_ID(d)) uut (
      .clk(clk), .rstN(rstN), .pollStrap(pollStrap), .strobe(strobe),
      .devAddr(devAddr), .queueFlagN(qf[d]), .selQueue(selQueue),
      .flagBus(busOut[d]), .busEn(en[d]), .flagN(fN[d])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setFlags(input int seed);
    for (int d = 0; d < ND; d++) qf[d] = 4'((seed * 3 + d * 7 + 5) & 15);
  endtask

  task automatic checkDiscrete(input logic [3:0] prev [ND], input logic [1:0] sel);
    for (int d = 0; d < ND; d++)
      chk(fN[d] == prev[d][sel], "R9", int'(fN[d]), int'(prev[d][sel]));
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0;
    pollStrap = strap;
    strobe = 1'b0;
    for (int d = 0; d < ND; d++) qf[d] = 4'h0;
    repeat (3) @(negedge clk);
    // R1: flags are all active during reset, outputs must stay idle
    chk(en == '0, "R1", int'(en), 0);
    chk(fN == '1, "R1", int'(fN), 15);
    rstN = 1'b1;
    pollStrap = ~strap;  // R2: late strap change must be ignored
  endtask

  initial begin
    logic [3:0] snap [ND];
    doReset(1'b0);
    // R2: direct mode kept, so idle edges leave the bus released
    repeat (3) @(negedge clk);
    chk(en == '0, "R2", int'(en), 0);

    for (int a = 0; a < ND; a++) begin
      for (int p = 0; p < 16; p++) begin
        setFlags(p + a * 16);
        strobe = 1'b1;
        devAddr = 2'(a);
        selQueue = 2'(p);
        snap = qf;
        @(negedge clk);
        for (int d = 0; d < ND; d++)
          chk(en[d] == (d == a), (d == a) ? "R3" : "R4", int'(en[d]), int'(d == a));
        chk($countones(en) == 1, "R3", $countones(en), 1);
        chk(busOut[a] == snap[a], "R3", int'(busOut[a]), int'(snap[a]));
        checkDiscrete(snap, 2'(p));
        // idle edge with new flags: snapshot must hold
        strobe = 1'b0;
        devAddr = 2'(a + 1);
        setFlags(p + a * 16 + 101);
        selQueue = 2'(p + 1);
        begin
          logic [3:0] cur [ND];
          cur = qf;
          @(negedge clk);
          for (int d = 0; d < ND; d++)
            chk(en[d] == (d == a), "R5", int'(en[d]), int'(d == a));
          chk(busOut[a] == snap[a], "R5", int'(busOut[a]), int'(snap[a]));
          checkDiscrete(cur, 2'(p + 1));
        end
      end
    end

    doReset(1'b1);
    for (int n = 1; n <= 40; n++) begin
      int expDev;
      expDev = (n - 1) % ND;
      setFlags(n * 11);
      strobe = n[0];
      devAddr = 2'(expDev + 1 + (n % 3));
      selQueue = 2'(n);
      snap = qf;
      @(negedge clk);
      for (int d = 0; d < ND; d++)
        chk(en[d] == (d == expDev), (n > ND && expDev == 0) ? "R8" : "R6",
            int'(en[d]), int'(d == expDev));
      chk($countones(en) == 1, "R6", $countones(en), 1);
      chk(busOut[expDev] == snap[expDev], "R6", int'(busOut[expDev]), int'(snap[expDev]));
      if (strobe)
        chk(!en[devAddr], "R7", int'(en[devAddr]), 0);
      if (n == 6) chk(en[1] == 1'b1, "R2", int'(en[1]), 1);
      checkDiscrete(snap, 2'(n));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule